// File: doc/BRIEF.md
# CAN Controller Command and Interrupt Unit

This block is the register-facing control unit of a CAN-style bus controller. Software drives it through a small register bus. A write to the command register starts a transmission, cancels one, advances the receive buffer or clears the overrun flag. A transmission can be a normal one, a single-shot one with no automatic retry, or a self-reception one. The unit turns these commands into one-cycle strobes toward the protocol engine. It tracks how full the receive buffer is and builds a status word from that and from the engine's state.

The unit also gathers engine events into latched interrupt flags: frame stored, transmit buffer freed, error-state changes, arbitration lost and bus error. Reading the interrupt register clears every latched flag. The receive flag is the exception: it follows the buffer contents. The arbitration-lost and bus-error sources each have a capture register. Once one of these sources fires, it stays silent until software reads its capture register. A single interrupt line is asserted while any enabled flag is pending.

The bit-level protocol engine, the frame storage and the acceptance filtering are not part of this block. They appear here only as stimulus ports.

Top module: `canctl_cmd_irq`

## Requirements
- R1: Register offsets are 0 mode (bit 0 = reset mode), 1 command, 2 status, 3 interrupt, 4 interrupt enable, 5 arbitration capture and 6 error-code capture. After reset the values are: mode 1, status 0x000C (bit 2 transmit buffer free, bit 3 transmit complete), interrupt 0, interrupt enable 0 and irq_o 0.
- R2: Command bit 0 starts a transmission, but only when the unit is outside reset mode and the transmit buffer is free. eng_tx_req then pulses for exactly one cycle after the write, and status bits 2 and 3 read 0 until the frame ends. A transmit command is ignored in reset mode or while a frame is pending or active.
- R3: Command bit 4 starts a self-reception transmission, which raises eng_tx_self together with the request. If command bit 1 (abort) is written together with bit 0 or bit 4, the request is single-shot: eng_tx_single is raised with the request and eng_tx_abort does not pulse. So 0x03 gives a single-shot transmit, 0x12 a single-shot self-reception and 0x10 a retried self-reception.
- R4: Command bit 1 pulses eng_tx_abort whenever the buffer is not free. If the engine has not started the frame (eng_tx_busy low), the frame is cancelled: status bits 2 and 3 become 1 and interrupt bit 1 is set. A frame already in progress is not cancelled, and the buffer stays busy until eng_tx_end.
- R5: eng_tx_end ends an active frame. Status bit 2 becomes 1, status bit 3 takes the value of eng_tx_ok, and interrupt bit 1 is set.
- R6: Each eng_rx_frame pulse stores one frame, up to RX_DEPTH frames. Status bit 0 is 1 while at least one frame is stored. Command bit 2 releases one frame and pulses eng_rx_release. A release with no stored frame does nothing and gives no pulse.
- R7: A frame that arrives while the buffer is full is dropped. Status bit 1 (overrun) and bit 8 (miss) are then set and the stored count does not change. Command bit 3 clears bit 1. Bit 8 clears when the next frame is stored.
- R8: A read of the interrupt register returns the pending flags and clears bits 1, 2, 5, 6 and 7. A flag raised in the same cycle as the read survives. Interrupt bit 0 equals status bit 0, and reading does not clear it.
- R9: A pulse on eng_arb_lost while armed stores eng_arb_pos into the arbitration capture register, sets interrupt bit 6 and disarms the source. While disarmed, further pulses leave both the flag and the capture unchanged. Reading the capture register re-arms the source.
- R10: eng_bus_err works the same way with eng_err_code, the error-code capture register and interrupt bit 7.
- R11: Status bits 4, 5, 6 and 7 show eng_rx_busy, eng_tx_busy, eng_err_warn and eng_bus_off. A change on eng_err_warn or eng_bus_off sets interrupt bit 2. A change on eng_err_passive sets interrupt bit 5. A rising edge of eng_bus_off forces the mode register into reset mode.
- R12: The interrupt enable register (implemented bits 0, 1, 2, 5, 6, 7; other bits read 0) accepts writes only in reset mode. irq_o is high while any pending flag has its enable bit set. Flags are latched whether or not they are enabled.
- R13: The command register always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt line |
| eng_tx_req | output | 1 | One-cycle transmit request |
| eng_tx_single | output | 1 | Request is single-shot |
| eng_tx_self | output | 1 | Request is self-reception |
| eng_tx_abort | output | 1 | One-cycle abort strobe |
| eng_rx_release | output | 1 | One-cycle receive buffer advance |
| eng_tx_busy | input | 1 | Engine is sending a frame |
| eng_rx_busy | input | 1 | Engine is receiving a frame |
| eng_tx_end | input | 1 | Active frame finished |
| eng_tx_ok | input | 1 | Finished frame succeeded |
| eng_rx_frame | input | 1 | A received frame is offered for storage |
| eng_err_warn | input | 1 | Error warning level |
| eng_bus_off | input | 1 | Bus-off level |
| eng_err_passive | input | 1 | Error passive level |
| eng_arb_lost | input | 1 | Arbitration lost event |
| eng_arb_pos | input | ARB_W | Bit position where arbitration was lost |
| eng_bus_err | input | 1 | Bus error event |
| eng_err_code | input | ECODE_W | Error code for the bus error |

## Verification
Some properties are checked by the assertions on every cycle. The request strobe is a single pulse and comes only from an idle buffer, and the single-shot qualifier never appears without a request. An in-progress frame survives an abort. The stored frame count never passes its depth. A dropped frame always raises overrun and miss. A disarmed capture register stays frozen. An interrupt-register read always removes the transmit flag unless a new event arrives. The enable register does not move outside reset mode, and bus-off always forces reset mode. Other behaviour shows only in the bench's directed scenarios, which compare status and interrupt values read over the bus. These cover the exact command encodings, the success or failure reported by the complete bit, the release-when-empty and overflow counts, the re-arm order of the capture registers, and masking of the interrupt line.

// File: rtl/canctl_pkg.sv
package canctl_pkg;

    // register offsets
    localparam int A_MODE   = 0;
    localparam int A_CMD    = 1;
    localparam int A_STAT   = 2;
    localparam int A_IRQ    = 3;
    localparam int A_IEN    = 4;
    localparam int A_ARBCAP = 5;
    localparam int A_ERRCAP = 6;

    // command bit positions
    localparam int CB_TX      = 0;
    localparam int CB_ABORT   = 1;
    localparam int CB_RELEASE = 2;
    localparam int CB_CLROVR  = 3;
    localparam int CB_SELF    = 4;
    localparam int CMD_W      = 5;

    // status bit positions
    localparam int ST_RXDATA  = 0;
    localparam int ST_OVR     = 1;
    localparam int ST_TXFREE  = 2;
    localparam int ST_TXDONE  = 3;
    localparam int ST_RXBUSY  = 4;
    localparam int ST_TXBUSY  = 5;
    localparam int ST_ERRWARN = 6;
    localparam int ST_BUSOFF  = 7;
    localparam int ST_MISS    = 8;
    localparam int STAT_W     = 9;

    // interrupt bit positions
    localparam int IQ_RX   = 0;
    localparam int IQ_TX   = 1;
    localparam int IQ_ERRW = 2;
    localparam int IQ_ERRP = 5;
    localparam int IQ_ARB  = 6;
    localparam int IQ_BERR = 7;
    localparam int IRQ_W   = 8;

    // flags held in storage and cleared by a read of the interrupt register
    localparam logic [IRQ_W-1:0] IRQ_LATCHED = 8'b1110_0110;
    // every implemented interrupt bit
    localparam logic [IRQ_W-1:0] IRQ_IMPL    = 8'b1110_0111;

    typedef struct packed {
        logic self_rx;
        logic clr_ovr;
        logic rel_buf;
        logic abort;
        logic tx;
    } cmd_t;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_PEND   = 2'd1,
        TX_ACTIVE = 2'd2
    } tx_state_e;

    function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] w);
        cmd_t c;
        c.tx      = w[CB_TX];
        c.abort   = w[CB_ABORT];
        c.rel_buf = w[CB_RELEASE];
        c.clr_ovr = w[CB_CLROVR];
        c.self_rx = w[CB_SELF];
        return c;
    endfunction

endpackage

// File: rtl/canctl_tx_ctrl.sv
module canctl_tx_ctrl
    import canctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_vld,
    input  cmd_t cmd,
    input  logic eng_busy,
    input  logic eng_end,
    input  logic eng_ok,
    output logic req_o,
    output logic single_o,
    output logic self_o,
    output logic abort_o,
    output logic buf_free_o,
    output logic complete_o,
    output logic irq_evt_o
);

    tx_state_e st;
    logic      want_tx;
    logic      start;
    logic      abort_eff;
    logic      cancel;

    always_comb begin
        want_tx   = cmd.tx || cmd.self_rx;
        start     = cmd_vld && want_tx && (st == TX_IDLE);
        abort_eff = cmd_vld && cmd.abort && (st != TX_IDLE);
        cancel    = abort_eff && (st == TX_PEND) && !eng_busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= TX_IDLE;
            complete_o <= 1'b1;
            req_o      <= 1'b0;
            single_o   <= 1'b0;
            self_o     <= 1'b0;
            abort_o    <= 1'b0;
            irq_evt_o  <= 1'b0;
        end else begin
            req_o     <= start;
            single_o  <= start && cmd.abort;
            self_o    <= start && cmd.self_rx;
            abort_o   <= abort_eff;
            irq_evt_o <= 1'b0;
            case (st)
                TX_IDLE: begin
                    if (start) begin
                        st         <= TX_PEND;
                        complete_o <= 1'b0;
                    end
                end
                TX_PEND: begin
                    if (cancel) begin
                        st         <= TX_IDLE;
                        complete_o <= 1'b1;
                        irq_evt_o  <= 1'b1;
                    end else if (eng_busy) begin
                        st <= TX_ACTIVE;
                    end
                end
                TX_ACTIVE: begin
                    if (eng_end) begin
                        st         <= TX_IDLE;
                        complete_o <= eng_ok;
                        irq_evt_o  <= 1'b1;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    assign buf_free_o = (st == TX_IDLE);

    // R2: request is a single pulse
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    // R2: a request only leaves an idle buffer
    a_r2_req_from_idle: assert property (@(posedge clk) disable iff (rst)
        req_o |-> !buf_free_o && $past(st == TX_IDLE));

    // R3: single-shot qualifier only accompanies a request
    a_r3_single_with_req: assert property (@(posedge clk) disable iff (rst)
        single_o |-> req_o);

    // R4: an in-progress frame is not cancelled by abort
    a_r4_active_survives: assert property (@(posedge clk) disable iff (rst)
        (st == TX_ACTIVE && !eng_end) |=> (st == TX_ACTIVE));

    // R5: frame end frees the buffer and raises the transmit event
    a_r5_end_frees: assert property (@(posedge clk) disable iff (rst)
        (st == TX_ACTIVE && eng_end) |=> (buf_free_o && irq_evt_o));

endmodule

// File: rtl/canctl_rx_track.sv
module canctl_rx_track #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_in,
    input  logic rel_cmd,
    input  logic clr_ovr_cmd,
    output logic has_data_o,
    output logic overrun_o,
    output logic miss_o,
    output logic rel_o
);

    localparam int          CW       = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0] cnt;
    logic          full;
    logic          empty;
    logic          do_rel;
    logic          store;
    logic          drop;

    always_comb begin
        full   = (cnt == FULL_CNT);
        empty  = (cnt == '0);
        do_rel = rel_cmd && !empty;
        store  = frame_in && (!full || do_rel);
        drop   = frame_in && full && !do_rel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            overrun_o <= 1'b0;
            miss_o    <= 1'b0;
            rel_o     <= 1'b0;
        end else begin
            rel_o <= do_rel;
            if (store && !do_rel) begin
                cnt <= cnt + 1'b1;
            end else if (!store && do_rel) begin
                cnt <= cnt - 1'b1;
            end
            if (drop) begin
                overrun_o <= 1'b1;
            end else if (clr_ovr_cmd) begin
                overrun_o <= 1'b0;
            end
            if (drop) begin
                miss_o <= 1'b1;
            end else if (store) begin
                miss_o <= 1'b0;
            end
        end
    end

    assign has_data_o = !empty;

    // R6: stored count never passes the depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

    // R6: release strobe only after a non-empty buffer
    a_r6_rel_nonempty: assert property (@(posedge clk) disable iff (rst)
        rel_cmd && empty |=> !rel_o);

    // R7: a dropped frame raises overrun and miss
    a_r7_drop_flags: assert property (@(posedge clk) disable iff (rst)
        (frame_in && full && !rel_cmd) |=> (overrun_o && miss_o && full));

endmodule

// File: rtl/canctl_irq_ctrl.sv
module canctl_irq_ctrl
    import canctl_pkg::*;
#(
    parameter int ARB_W   = 5,
    parameter int ECODE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_has_data,
    input  logic               tx_evt,
    input  logic               err_warn,
    input  logic               bus_off,
    input  logic               err_passive,
    input  logic               arb_lost,
    input  logic [ARB_W-1:0]   arb_pos,
    input  logic               bus_err,
    input  logic [ECODE_W-1:0] err_code,
    input  logic               rd_irq,
    input  logic               rd_arb,
    input  logic               rd_ecc,
    output logic [IRQ_W-1:0]   flags_o,
    output logic [ARB_W-1:0]   arb_cap_o,
    output logic [ECODE_W-1:0] ecc_o,
    output logic               boff_rise_o
);

    logic [IRQ_W-1:0] pend_q;
    logic [IRQ_W-1:0] set_vec;
    logic [IRQ_W-1:0] keep_mask;
    logic             warn_q, boff_q, pass_q;
    logic             arb_armed, ecc_armed;
    logic             arb_hit, ecc_hit;
    logic             warn_chg, pass_chg;

    always_comb begin
        warn_chg  = (err_warn ^ warn_q) || (bus_off ^ boff_q);
        pass_chg  = err_passive ^ pass_q;
        arb_hit   = arb_lost && arb_armed;
        ecc_hit   = bus_err && ecc_armed;
        set_vec          = '0;
        set_vec[IQ_TX]   = tx_evt;
        set_vec[IQ_ERRW] = warn_chg;
        set_vec[IQ_ERRP] = pass_chg;
        set_vec[IQ_ARB]  = arb_hit;
        set_vec[IQ_BERR] = ecc_hit;
        keep_mask = rd_irq ? ~IRQ_LATCHED : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            warn_q    <= 1'b0;
            boff_q    <= 1'b0;
            pass_q    <= 1'b0;
            arb_armed <= 1'b1;
            ecc_armed <= 1'b1;
            arb_cap_o <= '0;
            ecc_o     <= '0;
        end else begin
            pend_q <= ((pend_q & keep_mask) | set_vec) & IRQ_LATCHED;
            warn_q <= err_warn;
            boff_q <= bus_off;
            pass_q <= err_passive;
            if (arb_hit) begin
                arb_cap_o <= arb_pos;
                arb_armed <= 1'b0;
            end else if (rd_arb) begin
                arb_armed <= 1'b1;
            end
            if (ecc_hit) begin
                ecc_o     <= err_code;
                ecc_armed <= 1'b0;
            end else if (rd_ecc) begin
                ecc_armed <= 1'b1;
            end
        end
    end

    assign flags_o     = pend_q | {{(IRQ_W-1){1'b0}}, rx_has_data};
    assign boff_rise_o = bus_off && !boff_q;

    // R8: a read removes the transmit flag unless a new event arrives
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_irq && !tx_evt) |=> !flags_o[IQ_TX]);

    // R9: disarmed arbitration capture stays frozen
    a_r9_arb_frozen: assert property (@(posedge clk) disable iff (rst)
        (!arb_armed && !rd_arb) |=> (!arb_armed && $stable(arb_cap_o)));

    // R10: disarmed error-code capture stays frozen
    a_r10_ecc_frozen: assert property (@(posedge clk) disable iff (rst)
        (!ecc_armed && !rd_ecc) |=> (!ecc_armed && $stable(ecc_o)));

endmodule

// File: rtl/canctl_cmd_irq.sv
module canctl_cmd_irq
    import canctl_pkg::*;
#(
    parameter int AW       = 3,
    parameter int DW       = 16,
    parameter int RX_DEPTH = 4,
    parameter int ARB_W    = 5,
    parameter int ECODE_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               irq_o,
    output logic               eng_tx_req,
    output logic               eng_tx_single,
    output logic               eng_tx_self,
    output logic               eng_tx_abort,
    output logic               eng_rx_release,
    input  logic               eng_tx_busy,
    input  logic               eng_rx_busy,
    input  logic               eng_tx_end,
    input  logic               eng_tx_ok,
    input  logic               eng_rx_frame,
    input  logic               eng_err_warn,
    input  logic               eng_bus_off,
    input  logic               eng_err_passive,
    input  logic               eng_arb_lost,
    input  logic [ARB_W-1:0]   eng_arb_pos,
    input  logic               eng_bus_err,
    input  logic [ECODE_W-1:0] eng_err_code
);

    logic               reset_mode_q;
    logic [IRQ_W-1:0]   irq_en_q;
    logic               wr_mode, wr_cmd, wr_ien;
    logic               rd_irq, rd_arb, rd_ecc;
    logic               cmd_vld;
    cmd_t               cmd;
    logic               tx_free, tx_done, tx_evt;
    logic               rx_data, rx_ovr, rx_miss;
    logic [IRQ_W-1:0]   flags;
    logic [ARB_W-1:0]   arb_cap;
    logic [ECODE_W-1:0] ecc;
    logic               boff_rise;
    logic [STAT_W-1:0]  stat;

    always_comb begin
        wr_mode = bus_wr && (bus_addr == AW'(A_MODE));
        wr_cmd  = bus_wr && (bus_addr == AW'(A_CMD));
        wr_ien  = bus_wr && (bus_addr == AW'(A_IEN));
        rd_irq  = bus_rd && (bus_addr == AW'(A_IRQ));
        rd_arb  = bus_rd && (bus_addr == AW'(A_ARBCAP));
        rd_ecc  = bus_rd && (bus_addr == AW'(A_ERRCAP));
        cmd     = decode_cmd(bus_wdata[CMD_W-1:0]);
        cmd_vld = wr_cmd && !reset_mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_mode_q <= 1'b1;
            irq_en_q     <= '0;
        end else begin
            if (boff_rise) begin
                reset_mode_q <= 1'b1;
            end else if (wr_mode) begin
                reset_mode_q <= bus_wdata[0];
            end
            if (wr_ien && reset_mode_q) begin
                irq_en_q <= bus_wdata[IRQ_W-1:0] & IRQ_IMPL;
            end
        end
    end

    canctl_tx_ctrl u_tx (
        .clk        (clk),
        .rst        (rst),
        .cmd_vld    (cmd_vld),
        .cmd        (cmd),
        .eng_busy   (eng_tx_busy),
        .eng_end    (eng_tx_end),
        .eng_ok     (eng_tx_ok),
        .req_o      (eng_tx_req),
        .single_o   (eng_tx_single),
        .self_o     (eng_tx_self),
        .abort_o    (eng_tx_abort),
        .buf_free_o (tx_free),
        .complete_o (tx_done),
        .irq_evt_o  (tx_evt)
    );

    canctl_rx_track #(.DEPTH(RX_DEPTH)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .frame_in    (eng_rx_frame),
        .rel_cmd     (cmd_vld && cmd.rel_buf),
        .clr_ovr_cmd (cmd_vld && cmd.clr_ovr),
        .has_data_o  (rx_data),
        .overrun_o   (rx_ovr),
        .miss_o      (rx_miss),
        .rel_o       (eng_rx_release)
    );

    canctl_irq_ctrl #(.ARB_W(ARB_W), .ECODE_W(ECODE_W)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .rx_has_data (rx_data),
        .tx_evt      (tx_evt),
        .err_warn    (eng_err_warn),
        .bus_off     (eng_bus_off),
        .err_passive (eng_err_passive),
        .arb_lost    (eng_arb_lost),
        .arb_pos     (eng_arb_pos),
        .bus_err     (eng_bus_err),
        .err_code    (eng_err_code),
        .rd_irq      (rd_irq),
        .rd_arb      (rd_arb),
        .rd_ecc      (rd_ecc),
        .flags_o     (flags),
        .arb_cap_o   (arb_cap),
        .ecc_o       (ecc),
        .boff_rise_o (boff_rise)
    );

    always_comb begin
        stat             = '0;
        stat[ST_RXDATA]  = rx_data;
        stat[ST_OVR]     = rx_ovr;
        stat[ST_TXFREE]  = tx_free;
        stat[ST_TXDONE]  = tx_done;
        stat[ST_RXBUSY]  = eng_rx_busy;
        stat[ST_TXBUSY]  = eng_tx_busy;
        stat[ST_ERRWARN] = eng_err_warn;
        stat[ST_BUSOFF]  = eng_bus_off;
        stat[ST_MISS]    = rx_miss;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_MODE):   bus_rdata = DW'(reset_mode_q);
            AW'(A_STAT):   bus_rdata = DW'(stat);
            AW'(A_IRQ):    bus_rdata = DW'(flags);
            AW'(A_IEN):    bus_rdata = DW'(irq_en_q);
            AW'(A_ARBCAP): bus_rdata = DW'(arb_cap);
            AW'(A_ERRCAP): bus_rdata = DW'(ecc);
            default:       bus_rdata = '0;
        endcase
    end

    assign irq_o = |(flags & irq_en_q);

    // R12: enable register does not move outside reset mode
    a_r12_en_locked: assert property (@(posedge clk) disable iff (rst)
        !reset_mode_q |=> $stable(irq_en_q));

    // R11: bus-off entry forces reset mode
    a_r11_busoff_reset: assert property (@(posedge clk) disable iff (rst)
        boff_rise |=> reset_mode_q);

    // R2: no transmit request follows a command written in reset mode
    a_r2_reset_blocks: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && reset_mode_q) |=> !eng_tx_req);

endmodule

// File: tb/test_canctl_cmd_irq.sv
module test_canctl_cmd_irq;
    import canctl_pkg::*;

    localparam int AW = 3;
    localparam int DW = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr = 0, bus_rd = 0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic           irq_o;
    logic           eng_tx_req, eng_tx_single, eng_tx_self, eng_tx_abort, eng_rx_release;
    logic           eng_tx_busy = 0, eng_rx_busy = 0, eng_tx_end = 0, eng_tx_ok = 0;
    logic           eng_rx_frame = 0;
    logic           eng_err_warn = 0, eng_bus_off = 0, eng_err_passive = 0;
    logic           eng_arb_lost = 0, eng_bus_err = 0;
    logic [4:0]     eng_arb_pos = '0;
    logic [7:0]     eng_err_code = '0;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] v;

    always #4 clk = ~clk;

    canctl_cmd_irq i_canctl_cmd_irq (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .eng_tx_req(eng_tx_req), .eng_tx_single(eng_tx_single), .eng_tx_self(eng_tx_self),
        .eng_tx_abort(eng_tx_abort), .eng_rx_release(eng_rx_release),
        .eng_tx_busy(eng_tx_busy), .eng_rx_busy(eng_rx_busy), .eng_tx_end(eng_tx_end),
        .eng_tx_ok(eng_tx_ok), .eng_rx_frame(eng_rx_frame), .eng_err_warn(eng_err_warn),
        .eng_bus_off(eng_bus_off), .eng_err_passive(eng_err_passive),
        .eng_arb_lost(eng_arb_lost), .eng_arb_pos(eng_arb_pos),
        .eng_bus_err(eng_bus_err), .eng_err_code(eng_err_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = AW'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic rx_pulse();
        @(negedge clk); eng_rx_frame = 1;
        @(negedge clk); eng_rx_frame = 0;
    endtask

    task automatic tx_finish(input logic ok);
        @(negedge clk); eng_tx_busy = 1;
        @(negedge clk); eng_tx_end = 1; eng_tx_ok = ok;
        @(negedge clk); eng_tx_end = 0; eng_tx_busy = 0; eng_tx_ok = 0;
    endtask

    task automatic t_reset();
        rd(A_MODE, v); chk("R1 mode", v, 16'h1);
        rd(A_STAT, v); chk("R1 status", v, 16'h000C);
        rd(A_IRQ, v);  chk("R1 irq", v, 16'h0);
        rd(A_IEN, v);  chk("R1 ien", v, 16'h0);
        chk("R1 irq_o", irq_o, 0);
    endtask

    task automatic t_reset_mode_block();
        wr(A_CMD, 16'h0001);
        chk("R2 no req in reset mode", eng_tx_req, 0);
        rd(A_STAT, v); chk("R2 buffer stays free in reset mode", v & 16'h000C, 16'h000C);
        rd(A_CMD, v);  chk("R13 cmd reads zero", v, 16'h0);
    endtask

    task automatic t_ien();
        wr(A_IEN, 16'h00FF);
        rd(A_IEN, v); chk("R12 ien implemented bits", v, 16'h00E7);
        wr(A_MODE, 16'h0000);
        rd(A_MODE, v); chk("R12 left reset mode", v, 16'h0);
        wr(A_IEN, 16'h0000);
        rd(A_IEN, v); chk("R12 ien locked outside reset mode", v, 16'h00E7);
    endtask

    task automatic t_tx_basic();
        wr(A_CMD, 16'h0001);
        chk("R2 req pulse", eng_tx_req, 1);
        chk("R2 req not single", eng_tx_single, 0);
        chk("R2 req not self", eng_tx_self, 0);
        @(negedge clk);
        chk("R2 req one cycle", eng_tx_req, 0);
        rd(A_STAT, v); chk("R2 buffer busy", v & 16'h000C, 16'h0);
        wr(A_CMD, 16'h0001);
        chk("R2 second tx ignored while pending", eng_tx_req, 0);
        @(negedge clk); eng_tx_busy = 1;
        @(negedge clk);
        rd(A_STAT, v); chk("R11 transmitting bit", v & 16'h0024, 16'h0020);
        eng_tx_end = 1; eng_tx_ok = 1;
        @(negedge clk); eng_tx_end = 0; eng_tx_busy = 0; eng_tx_ok = 0;
        rd(A_STAT, v); chk("R5 done ok", v & 16'h002C, 16'h000C);
        chk("R12 irq_o on tx flag", irq_o, 1);
        rd(A_IRQ, v);  chk("R5 tx irq", v, 16'h0002);
        rd(A_IRQ, v);  chk("R8 read cleared tx flag", v, 16'h0);
        chk("R8 irq_o low after clear", irq_o, 0);
    endtask

    task automatic t_tx_fail();
        wr(A_CMD, 16'h0001);
        tx_finish(0);
        rd(A_STAT, v); chk("R5 done failed", v & 16'h000C, 16'h0004);
        rd(A_IRQ, v);  chk("R5 tx irq after fail", v, 16'h0002);
    endtask

    task automatic t_single();
        wr(A_CMD, 16'h0003);
        chk("R3 0x03 req", eng_tx_req, 1);
        chk("R3 0x03 single", eng_tx_single, 1);
        chk("R3 0x03 no self", eng_tx_self, 0);
        chk("R3 0x03 no abort", eng_tx_abort, 0);
        tx_finish(1);
        rd(A_IRQ, v);
        wr(A_CMD, 16'h0012);
        chk("R3 0x12 single", {eng_tx_req, eng_tx_single, eng_tx_self, eng_tx_abort}, 4'b1110);
        tx_finish(1);
        rd(A_IRQ, v);
        wr(A_CMD, 16'h0010);
        chk("R3 0x10 self retried", {eng_tx_req, eng_tx_single, eng_tx_self}, 3'b101);
    endtask

    task automatic t_abort();
        // frame from t_single still pending
        wr(A_CMD, 16'h0002);
        chk("R4 abort strobe pending", eng_tx_abort, 1);
        rd(A_STAT, v); chk("R4 pending cancelled", v & 16'h000C, 16'h000C);
        rd(A_IRQ, v);  chk("R4 tx irq on cancel", v, 16'h0002);
        wr(A_CMD, 16'h0001);
        @(negedge clk); eng_tx_busy = 1;
        @(negedge clk);
        wr(A_CMD, 16'h0002);
        chk("R4 abort strobe active", eng_tx_abort, 1);
        rd(A_STAT, v); chk("R4 active frame kept", v & 16'h0024, 16'h0020);
        eng_tx_end = 1; eng_tx_ok = 1;
        @(negedge clk); eng_tx_end = 0; eng_tx_busy = 0; eng_tx_ok = 0;
        rd(A_STAT, v); chk("R4 freed at end", v & 16'h000C, 16'h000C);
        rd(A_IRQ, v);
        wr(A_CMD, 16'h0002);
        chk("R4 no abort when free", eng_tx_abort, 0);
    endtask

    task automatic t_rx();
        rx_pulse();
        rd(A_STAT, v); chk("R6 rx data", v & 16'h0001, 16'h1);
        chk("R12 irq_o on rx", irq_o, 1);
        rd(A_IRQ, v);  chk("R8 rx flag", v, 16'h0001);
        rd(A_IRQ, v);  chk("R8 rx flag kept after read", v, 16'h0001);
        wr(A_CMD, 16'h0004);
        chk("R6 release strobe", eng_rx_release, 1);
        rd(A_STAT, v); chk("R6 empty after release", v & 16'h0001, 16'h0);
        wr(A_CMD, 16'h0004);
        chk("R6 release when empty ignored", eng_rx_release, 0);
        for (int i = 0; i < 4; i++) rx_pulse();
        rd(A_STAT, v); chk("R7 full no overrun", v & 16'h0103, 16'h0001);
        rx_pulse();
        rd(A_STAT, v); chk("R7 overrun and miss", v & 16'h0103, 16'h0103);
        for (int i = 0; i < 3; i++) wr(A_CMD, 16'h0004);
        rd(A_STAT, v); chk("R7 one frame left", v & 16'h0001, 16'h1);
        wr(A_CMD, 16'h0004);
        rd(A_STAT, v); chk("R7 count held at depth", v & 16'h0001, 16'h0);
        wr(A_CMD, 16'h0008);
        rd(A_STAT, v); chk("R7 overrun cleared, miss kept", v & 16'h0102, 16'h0100);
        rx_pulse();
        rd(A_STAT, v); chk("R7 miss cleared by store", v & 16'h0101, 16'h0001);
        wr(A_CMD, 16'h0004);
    endtask

    task automatic t_err();
        @(negedge clk); eng_err_warn = 1;
        rd(A_STAT, v); chk("R11 warn status", v & 16'h00C0, 16'h0040);
        rd(A_IRQ, v);  chk("R11 warn irq", v, 16'h0004);
        @(negedge clk); eng_err_passive = 1;
        rd(A_IRQ, v);  chk("R11 passive irq", v, 16'h0020);
        @(negedge clk); eng_bus_off = 1;
        rd(A_MODE, v); chk("R11 bus-off forces reset mode", v, 16'h1);
        rd(A_STAT, v); chk("R11 bus-off status", v & 16'h00C0, 16'h00C0);
        rd(A_IRQ, v);  chk("R11 bus-off irq", v, 16'h0004);
        @(negedge clk); eng_bus_off = 0; eng_err_warn = 0; eng_err_passive = 0;
        rd(A_IRQ, v);  chk("R11 recovery irq", v, 16'h0024);
        wr(A_MODE, 16'h0000);
    endtask

    task automatic t_arb();
        @(negedge clk); eng_arb_lost = 1; eng_arb_pos = 5'd13;
        @(negedge clk); eng_arb_lost = 0;
        rd(A_IRQ, v); chk("R9 arb irq", v, 16'h0040);
        @(negedge clk); eng_arb_lost = 1; eng_arb_pos = 5'd7;
        @(negedge clk); eng_arb_lost = 0;
        rd(A_IRQ, v); chk("R9 disarmed no irq", v, 16'h0);
        rd(A_ARBCAP, v); chk("R9 capture frozen", v, 16'd13);
        @(negedge clk); eng_arb_lost = 1;
        @(negedge clk); eng_arb_lost = 0;
        rd(A_IRQ, v); chk("R9 rearmed irq", v, 16'h0040);
        rd(A_ARBCAP, v); chk("R9 new capture", v, 16'd7);
    endtask

    task automatic t_berr();
        @(negedge clk); eng_bus_err = 1; eng_err_code = 8'h5A;
        @(negedge clk); eng_bus_err = 0;
        rd(A_IRQ, v); chk("R10 bus error irq", v, 16'h0080);
        @(negedge clk); eng_bus_err = 1; eng_err_code = 8'h33;
        @(negedge clk); eng_bus_err = 0;
        rd(A_IRQ, v); chk("R10 disarmed no irq", v, 16'h0);
        rd(A_ERRCAP, v); chk("R10 capture frozen", v, 16'h005A);
        @(negedge clk); eng_bus_err = 1;
        @(negedge clk); eng_bus_err = 0;
        rd(A_ERRCAP, v); chk("R10 new capture", v, 16'h0033);
        // read of the interrupt register in the same cycle as a new event keeps it (R8)
        @(negedge clk);
        bus_rd = 1; bus_addr = AW'(A_IRQ); eng_bus_err = 1;
        @(negedge clk);
        bus_rd = 0; eng_bus_err = 0;
        rd(A_IRQ, v); chk("R8 event beats clearing read", v, 16'h0080);
    endtask

    task automatic t_mask();
        wr(A_MODE, 16'h0001);
        wr(A_IEN, 16'h0001);
        wr(A_MODE, 16'h0000);
        @(negedge clk); eng_arb_lost = 1; eng_arb_pos = 5'd2;
        @(negedge clk); eng_arb_lost = 0;
        chk("R12 masked flag keeps irq_o low", irq_o, 0);
        rd(A_IRQ, v); chk("R12 masked flag still latched", v, 16'h0040);
        rx_pulse();
        chk("R12 enabled rx drives irq_o", irq_o, 1);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_reset_mode_block();
        t_ien();
        t_tx_basic();
        t_tx_fail();
        t_single();
        t_abort();
        t_rx();
        t_err();
        t_arb();
        t_berr();
        t_mask();
        report();
    end

endmodule